// File: doc/BRIEF.md
# HI/LO Integer Divide Unit

This block performs 32-bit integer division for a MIPS-style core and holds the results in two dedicated result registers, HI and LO. The core presents an operation strobe together with a six-bit function code and two operands. Two codes start a division (signed or unsigned). Two other codes read back HI or LO. Any other code is ignored. The quotient lands in LO and the remainder lands in HI.

Ordinary operands go through a restoring shift-subtract loop that resolves one quotient bit per clock. Signed operands are turned into magnitudes first, and the signs are fixed up when the loop ends. Division by zero and the most-negative-by-minus-one case do not trap. They finish in one cycle with fixed HI/LO values. While the loop runs, `busy` is high and a read request is parked. That read is answered in the same cycle that the new results are written.

Top module: `hilo_divider`

## Requirements
- R1: After reset, HI and LO both read 0xDEADDEAD, and `busy`, `done` and `rd_valid` are low.
- R2: An unsigned divide (function code 0x1B) leaves the unsigned quotient in LO and the remainder in HI.
- R3: A signed divide (function code 0x1A) truncates the quotient toward zero, and the remainder takes the dividend's sign.
- R4: A signed divide with a zero divisor sets HI to the dividend. It sets LO to 0xFFFFFFFF when the dividend is non-negative and to 1 when it is negative.
- R5: An unsigned divide with a zero divisor sets HI to the dividend and LO to 0xFFFFFFFF.
- R6: A signed divide of 0x80000000 by 0xFFFFFFFF (-1) sets HI to 0 and LO to 0x80000000, with no trap.
- R7: A normal divide raises `busy` in the cycle after the strobe and holds it for exactly 32 cycles. `done` is then high for one cycle, the first cycle after `busy` falls. A special-case divide (R4, R5, R6) raises `done` in the cycle right after the strobe and never raises `busy`. HI and LO change only at the edge that raises `done`.
- R8: When the unit is idle, a request with code 0x10 returns HI and a request with code 0x12 returns LO on `rd_data`, with `rd_valid` high for the one cycle after the request.
- R9: A read request that arrives while `busy` is high is held. It is answered with the new HI or LO value in the cycle where `done` is high, and that includes a request made in the last busy cycle.
- R10: A divide strobe while `busy` is high is ignored: the running result, its timing and the single `done` pulse are unaffected.
- R11: A request with any other function code produces no `rd_valid`, no `busy` and no `done`, and leaves HI and LO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Operation strobe, one cycle per operation |
| func | input | 6 | Function code of the operation |
| opnd_s | input | 32 | Dividend |
| opnd_t | input | 32 | Divisor |
| busy | output | 1 | Iterative divide in progress |
| done | output | 1 | One-cycle pulse: HI/LO have just been written |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | HI or LO read data |

## Verification
Two of this block's functions can land in the same cycle: the completion of a divide and the answer to a read request that waits on it. The bench provokes this in two ways. It issues a HI or LO read in the middle of a running divide, and it issues one in the very last busy cycle, where the request reaches the unit at the edge that writes the results. In both cases the scoreboard expects `rd_valid` and `done` high together, with `rd_data` already equal to the new result and not the stale one. A divide strobe injected mid-run is judged the same way: the final HI/LO must come from the first operands, and only one `done` pulse may appear.

// File: rtl/hilo_divider.sv
module hilo_divider #(
  parameter int              W         = 32,
  parameter logic [W-1:0]    RESET_VAL = 32'hDEADDEAD,
  parameter logic [5:0]      F_MFHI    = 6'h10,
  parameter logic [5:0]      F_MFLO    = 6'h12,
  parameter logic [5:0]      F_DIV     = 6'h1A,
  parameter logic [5:0]      F_DIVU    = 6'h1B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [5:0]   func,
  input  logic [W-1:0] opnd_s,
  input  logic [W-1:0] opnd_t,
  output logic         busy,
  output logic         done,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);

  localparam int           CW   = $clog2(W);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0]  hi_q, lo_q, rem_q, quo_q, dvs_q, rd_data_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, rd_valid_q, qneg_q, rneg_q, pend_q, psel_q;

  wire is_div   = req && (func == F_DIV || func == F_DIVU);
  wire is_rd    = req && (func == F_MFHI || func == F_MFLO);
  wire sgn      = (func == F_DIV);
  wire neg_s    = sgn && opnd_s[W-1];
  wire neg_t    = sgn && opnd_t[W-1];
  wire zero_div = (opnd_t == '0);
  wire ovf      = sgn && (opnd_s == MINV) && (opnd_t == ONES);

  wire [W-1:0] mag_s = neg_s ? -opnd_s : opnd_s;
  wire [W-1:0] mag_t = neg_t ? -opnd_t : opnd_t;
  wire [W-1:0] sp_hi = zero_div ? opnd_s : '0;
  wire [W-1:0] sp_lo = zero_div ? (neg_s ? ONE : ONES) : MINV;

  wire [W:0]   trial = {rem_q, quo_q[W-1]} - {1'b0, dvs_q};
  wire         take  = !trial[W];
  wire [W-1:0] rem_n = take ? trial[W-1:0] : {rem_q[W-2:0], quo_q[W-1]};
  wire [W-1:0] quo_n = {quo_q[W-2:0], take};
  wire [W-1:0] fin_q = qneg_q ? -quo_n : quo_n;
  wire [W-1:0] fin_r = rneg_q ? -rem_n : rem_n;
  wire         last  = busy_q && (cnt_q == CW'(W-1));
  wire         rsel  = pend_q ? psel_q : (func == F_MFHI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q       <= RESET_VAL;
      lo_q       <= RESET_VAL;
      rem_q      <= '0;
      quo_q      <= '0;
      dvs_q      <= '0;
      rd_data_q  <= '0;
      cnt_q      <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      qneg_q     <= 1'b0;
      rneg_q     <= 1'b0;
      pend_q     <= 1'b0;
      psel_q     <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      if (busy_q) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
        cnt_q <= cnt_q + 1'b1;
        if (is_rd && !pend_q) begin
          pend_q <= 1'b1;
          psel_q <= (func == F_MFHI);
        end
        if (last) begin
          busy_q <= 1'b0;
          hi_q   <= fin_r;
          lo_q   <= fin_q;
          done_q <= 1'b1;
          if (pend_q || is_rd) begin
            rd_valid_q <= 1'b1;
            rd_data_q  <= rsel ? fin_r : fin_q;
            pend_q     <= 1'b0;
          end
        end
      end else if (is_div) begin
        if (zero_div || ovf) begin
          hi_q   <= sp_hi;
          lo_q   <= sp_lo;
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          rem_q  <= '0;
          quo_q  <= mag_s;
          dvs_q  <= mag_t;
          qneg_q <= neg_s ^ neg_t;
          rneg_q <= neg_s;
        end
      end else if (is_rd) begin
        rd_valid_q <= 1'b1;
        rd_data_q  <= (func == F_MFHI) ? hi_q : lo_q;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  // R7
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R7
  hilo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(hi_q) && $stable(lo_q)));

  // R9
  rd_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |-> !busy_q);

endmodule

// File: tb/hilo_divider_bench.sv
module hilo_divider_bench;
  localparam logic [5:0] F_MFHI = 6'h10, F_MFLO = 6'h12, F_DIV = 6'h1A, F_DIVU = 6'h1B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [5:0]  func = '0;
  logic [31:0] opnd_s = '0, opnd_t = '0;
  logic        busy, done, rd_valid;
  logic [31:0] rd_data;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] q_data[$];
  bit          q_done[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  hilo_divider u_hilo_divider (
    .clk(clk), .rst_n(rst_n), .req(req), .func(func),
    .opnd_s(opnd_s), .opnd_t(opnd_t),
    .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic model(input bit sgn, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] h, output logic [31:0] l);
    int sa, sb;
    sa = a; sb = b;
    if (b == 0) begin
      h = a;
      l = (sgn && a[31]) ? 32'h1 : 32'hFFFFFFFF;
    end else if (sgn && a == 32'h80000000 && b == 32'hFFFFFFFF) begin
      h = 0; l = 32'h80000000;
    end else if (sgn) begin
      l = sa / sb; h = sa % sb;
    end else begin
      l = a / b; h = a % b;
    end
  endtask

  task automatic push(input logic [31:0] d, input bit dn, input string tag);
    q_data.push_back(d); q_done.push_back(dn); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (q_data.size() == 0) chk(0, "R11 unexpected rd_valid", rd_data, 32'h0);
      else begin
        logic [31:0] e; bit ed; string t;
        e = q_data.pop_front(); ed = q_done.pop_front(); t = q_tag.pop_front();
        chk(rd_data == e, t, rd_data, e);
        chk(done == ed, {t, " done alignment"}, {31'b0, done}, {31'b0, ed});
      end
    end
  end

  task automatic rd(input logic [5:0] f, input logic [31:0] e, input string tag);
    push(e, 0, tag);
    req = 1; func = f;
    @(negedge clk);
    req = 0;
    @(negedge clk);
  endtask

  task automatic do_div(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                        input int rd_at, input logic [5:0] rf, input int ign_at, input string tag);
    logic [31:0] eh, el;
    bit special;
    int n;
    model(f == F_DIV, a, b, eh, el);
    special = (b == 0) || (f == F_DIV && a == 32'h80000000 && b == 32'hFFFFFFFF);
    req = 1; func = f; opnd_s = a; opnd_t = b;
    @(negedge clk);
    req = 0;
    chk(busy == !special, {tag, " R7 busy after strobe"}, {31'b0, busy}, {31'b0, !special});
    n = 0;
    while (!done && n < 100) begin
      req = 0;
      if (n == rd_at) begin
        req = 1; func = rf;
        push(rf == F_MFHI ? eh : el, 1, {tag, " R9 held read"});
      end
      if (n == ign_at) begin
        req = 1; func = F_DIVU; opnd_s = 32'd1; opnd_t = 32'd1;
      end
      @(negedge clk);
      n++;
    end
    req = 0;
    chk(n == (special ? 0 : 32), {tag, " R7 latency"}, n, special ? 0 : 32);
    chk(!busy, {tag, " R7 busy low at done"}, {31'b0, busy}, 32'h0);
    @(negedge clk);
    chk(!done && !busy, {tag, " R7/R10 single done"}, {30'b0, busy, done}, 32'h0);
    rd(F_MFHI, eh, {tag, " HI"});
    rd(F_MFLO, el, {tag, " LO"});
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!busy && !done && !rd_valid, "R1 reset outputs", {29'b0, busy, done, rd_valid}, 32'h0);
    rd(F_MFHI, 32'hDEADDEAD, "R1 R8 HI reset");
    rd(F_MFLO, 32'hDEADDEAD, "R1 R8 LO reset");
    // R2
    do_div(F_DIVU, 32'd100, 32'd7, -1, F_MFLO, -1, "R2 100/7");
    do_div(F_DIVU, 32'hFFFFFFFF, 32'd3, -1, F_MFLO, -1, "R2 max/3");
    do_div(F_DIVU, 32'd5, 32'd9, -1, F_MFLO, -1, "R2 5/9");
    do_div(F_DIVU, 32'h80000000, 32'hFFFFFFFF, -1, F_MFLO, -1, "R2 min/ones");
    // R3
    do_div(F_DIV, -32'sd7, 32'd2, -1, F_MFLO, -1, "R3 -7/2");
    do_div(F_DIV, 32'd7, -32'sd2, -1, F_MFLO, -1, "R3 7/-2");
    do_div(F_DIV, -32'sd7, -32'sd2, -1, F_MFLO, -1, "R3 -7/-2");
    do_div(F_DIV, 32'h80000000, 32'd2, -1, F_MFLO, -1, "R3 min/2");
    // R4
    do_div(F_DIV, 32'd5, 32'd0, -1, F_MFLO, -1, "R4 5/0");
    do_div(F_DIV, -32'sd5, 32'd0, -1, F_MFLO, -1, "R4 -5/0");
    // R5
    do_div(F_DIVU, 32'hFFFFFFFF, 32'd0, -1, F_MFLO, -1, "R5 max/0");
    do_div(F_DIVU, 32'd0, 32'd0, -1, F_MFLO, -1, "R5 0/0");
    // R6
    do_div(F_DIV, 32'h80000000, 32'hFFFFFFFF, -1, F_MFLO, -1, "R6 min/-1");
    // R9 collision of held read and completion
    do_div(F_DIVU, 32'd1000, 32'd33, 10, F_MFLO, -1, "R9 mid LO");
    do_div(F_DIV, -32'sd1000, 32'd33, 31, F_MFHI, -1, "R9 last HI");
    // R10
    do_div(F_DIVU, 32'd77777, 32'd123, -1, F_MFLO, 5, "R10 ignored start");
    // R11
    req = 1; func = 6'h18; opnd_s = 32'd9; opnd_t = 32'd3;
    @(negedge clk);
    req = 0;
    chk(!busy && !done && !rd_valid, "R11 other code", {29'b0, busy, done, rd_valid}, 32'h0);
    @(negedge clk);
    chk(!busy && !done && !rd_valid, "R11 other code later", {29'b0, busy, done, rd_valid}, 32'h0);
    rd(F_MFHI, 32'd77777 % 32'd123, "R11 HI unchanged");
    rd(F_MFLO, 32'd77777 / 32'd123, "R11 LO unchanged");
    repeat (3) @(negedge clk);
    chk(q_data.size() == 0, "R8 all reads answered", q_data.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule